// File: doc/BRIEF.md
# Coded-Setting Watchdog Timer

This block is a watchdog timer that software drives through a single byte-wide control register. The low three bits of that register carry a setting code. Each code either turns the timer off or picks a pair of durations: a startup delay and a timeout period. Both durations are measured in ticks of an external time base. Bit 3 is the kick bit. A rising edge on it tells the timer that software is alive. When the timeout period runs out with no kick, the block raises a reset pulse of fixed length.

A code with a nonzero startup delay waits for that delay to elapse first, then starts watching. Kicks that arrive during the delay are ignored. A code with no startup delay stays idle until software delivers its first kick, and timing starts from that kick. Once a reset pulse has ended, the block goes back to the start of the current code's sequence. Writing a different code restarts the sequence at once. The upper four register bits are plain storage.

Top module: `wdg_top`

## Requirements
- R1: After reset the register reads 0x03, so the timer is disabled and the reset output is low. All eight bits written are read back unchanged.
- R2: Codes 0, 3 and 4 disable the timer. With any of these codes the reset output never asserts, whatever ticks or kicks arrive.
- R3: A kick is a 0-to-1 transition of register bit 3 on a write. Writing 1 to bit 3 when it already holds 1 is not a kick, and neither is writing 0.
- R4: Code 1 uses a startup delay of 3 ticks and a timeout of 3 ticks.
- R5: Code 2 uses a delay of 60 ticks and a timeout of 1 tick. Code 7 uses a delay of 60 ticks and a timeout of 10 ticks.
- R6: Code 5 uses no delay and a timeout of 1 tick. Code 6 uses no delay and a timeout of 10 ticks.
- R7: Under a zero-delay code the timer stays idle, with no reset for any number of ticks, until the first kick. Timing starts at that kick.
- R8: Under a nonzero-delay code, kicks during the delay have no effect. The timeout count starts only after the full delay has elapsed, so the reset comes exactly delay plus timeout ticks after the code write.
- R9: The counters advance only in clock cycles where tick is high. Any number of clock cycles without a tick never causes a reset.
- R10: A timeout raises the reset output for exactly PULSE_LEN clock cycles, starting in the cycle after the expiring tick. The block then repeats the current code's sequence: the delay again, or a wait for a kick.
- R11: A write that changes the code restarts the sequence of the new code. A write that changes only bits 7:4 or the kick bit does not disturb the running count.
- R12: A kick while the timeout is running restarts the count, so the reset comes after a further full timeout period of ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data: [2:0] code, [3] kick bit, [7:4] storage |
| rd_data | output | 8 | Current register contents |
| tick | input | 1 | One-cycle time-base enable |
| wdg_rst | output | 1 | Watchdog reset pulse |

## Verification
The bench sweeps all eight codes. For each enabled code it checks that the reset arrives exactly on the tick the arithmetic predicts. A design with an off-by-one counter compare would fire one tick early or late, and one that skipped the delay would fire after the timeout alone. Zero-delay codes are left unkicked for many ticks, which catches a design that starts timing at the code write. The bench also rewrites a kick bit that is already set: a design that kicks on the level rather than the edge would push the reset back. A kick during the delay, a long run of ticks-free clocks, and writes that touch only bits 7:4 show whether the design wrongly restarts or advances its count.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int TW = 8;  // tick counter width, holds the largest duration

    typedef enum logic [2:0] {
        ST_OFF,
        ST_ARMWAIT,
        ST_DELAY,
        ST_RUN,
        ST_FIRE
    } wdg_state_e;

    typedef struct packed {
        logic          enabled;
        logic [TW-1:0] delay;
        logic [TW-1:0] timeout;
    } wdg_timing_t;

    function automatic wdg_timing_t decode_code(input logic [2:0] c);
        wdg_timing_t t;
        case (c)
            3'd1:    t = '{enabled: 1'b1, delay: TW'(3),  timeout: TW'(3)};
            3'd2:    t = '{enabled: 1'b1, delay: TW'(60), timeout: TW'(1)};
            3'd5:    t = '{enabled: 1'b1, delay: TW'(0),  timeout: TW'(1)};
            3'd6:    t = '{enabled: 1'b1, delay: TW'(0),  timeout: TW'(10)};
            3'd7:    t = '{enabled: 1'b1, delay: TW'(60), timeout: TW'(10)};
            default: t = '{enabled: 1'b0, delay: '0,      timeout: '0};
        endcase
        return t;
    endfunction

    function automatic logic code_enabled(input logic [2:0] c);
        return (c == 3'd1) || (c == 3'd2) || (c == 3'd5) || (c == 3'd6) || (c == 3'd7);
    endfunction

endpackage

// File: rtl/wdg_ctrl_reg.sv
module wdg_ctrl_reg #(
    parameter logic [7:0] RESET_VAL = 8'h03
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic [2:0] code_q,
    output logic [2:0] next_code,
    output logic       kick_evt,
    output logic       code_chg
);
    logic [7:0] ctl_q;

    always_ff @(posedge clk) begin
        if (rst)        ctl_q <= RESET_VAL;
        else if (wr_en) ctl_q <= wr_data;
    end

    assign rd_data   = ctl_q;
    assign code_q    = ctl_q[2:0];
    assign next_code = wr_en ? wr_data[2:0] : ctl_q[2:0];
    assign kick_evt  = wr_en & wr_data[3] & ~ctl_q[3];
    assign code_chg  = wr_en & (wr_data[2:0] != ctl_q[2:0]);

    // R3: a kick event is always followed by a stored kick bit of 1
    a_r3_kick_stored: assert property (@(posedge clk) disable iff (rst)
        kick_evt |=> rd_data[3]);

    // R11: a code change is always visible in the stored code next cycle
    a_r11_code_stored: assert property (@(posedge clk) disable iff (rst)
        code_chg |=> !$stable(code_q));

endmodule

// File: rtl/wdg_seq.sv
module wdg_seq
    import wdg_pkg::*;
#(
    parameter int PULSE_LEN = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic [2:0] code_q,
    input  logic [2:0] next_code,
    input  logic       kick_evt,
    input  logic       code_chg,
    output logic       rst_out
);
    localparam int PW = $clog2(PULSE_LEN + 1);

    wdg_state_e    state_q, state_d;
    logic [TW-1:0] cnt_q, cnt_d;
    logic [PW-1:0] pcnt_q, pcnt_d;
    wdg_timing_t   tm;
    logic          restart;

    always_comb begin
        tm      = decode_code(next_code);
        state_d = state_q;
        cnt_d   = cnt_q;
        pcnt_d  = pcnt_q;
        restart = code_chg;
        case (state_q)
            ST_ARMWAIT: if (kick_evt) begin
                state_d = ST_RUN;
                cnt_d   = '0;
            end
            ST_DELAY: if (tick) begin
                if (cnt_q == tm.delay - TW'(1)) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + TW'(1);
                end
            end
            ST_RUN: begin
                if (kick_evt) begin
                    cnt_d = '0;
                end else if (tick) begin
                    if (cnt_q == tm.timeout - TW'(1)) begin
                        state_d = ST_FIRE;
                        pcnt_d  = '0;
                    end else begin
                        cnt_d = cnt_q + TW'(1);
                    end
                end
            end
            ST_FIRE: begin
                if (pcnt_q == PW'(PULSE_LEN - 1)) restart = 1'b1;
                else                              pcnt_d = pcnt_q + PW'(1);
            end
            default: ;
        endcase
        if (restart) begin
            cnt_d  = '0;
            pcnt_d = '0;
            if (!tm.enabled)          state_d = ST_OFF;
            else if (tm.delay == '0)  state_d = ST_ARMWAIT;
            else                      state_d = ST_DELAY;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
            pcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            pcnt_q  <= pcnt_d;
        end
    end

    assign rst_out = (state_q == ST_FIRE);

    // R2: a disabled stored code never comes with a reset pulse
    a_r2_off_quiet: assert property (@(posedge clk) disable iff (rst)
        !code_enabled(code_q) |-> !rst_out);

    // R10: a pulse only begins out of the running timeout
    a_r10_fire_from_run: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_out) |-> $past(state_q == ST_RUN));

    // R10: the pulse counter stays inside the pulse length
    a_r10_pulse_bound: assert property (@(posedge clk) disable iff (rst)
        rst_out |-> (pcnt_q < PW'(PULSE_LEN)));

    // R11: a code change lands at the start of a sequence
    a_r11_restart_entry: assert property (@(posedge clk) disable iff (rst)
        code_chg |=> (state_q == ST_OFF || state_q == ST_ARMWAIT || state_q == ST_DELAY));

    // R7: waiting for the first kick persists without one
    a_r7_hold_wait: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ARMWAIT && !kick_evt && !code_chg) |=> state_q == ST_ARMWAIT);

    // R9: the timeout count is frozen in cycles without tick
    a_r9_no_tick_hold: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && !tick && !kick_evt && !code_chg) |=>
            (state_q == ST_RUN && $stable(cnt_q)));

endmodule

// File: rtl/wdg_top.sv
module wdg_top #(
    parameter int         PULSE_LEN = 4,
    parameter logic [7:0] RESET_VAL = 8'h03
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       tick,
    output logic       wdg_rst
);
    logic [2:0] code_q;
    logic [2:0] next_code;
    logic       kick_evt;
    logic       code_chg;

    wdg_ctrl_reg #(.RESET_VAL(RESET_VAL)) u_reg (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .code_q    (code_q),
        .next_code (next_code),
        .kick_evt  (kick_evt),
        .code_chg  (code_chg)
    );

    wdg_seq #(.PULSE_LEN(PULSE_LEN)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .code_q    (code_q),
        .next_code (next_code),
        .kick_evt  (kick_evt),
        .code_chg  (code_chg),
        .rst_out   (wdg_rst)
    );

endmodule

// File: tb/test_wdg_top.sv
module test_wdg_top;
    localparam int PL = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       tick = 1'b0;
    logic       wdg_rst;

    int n_tests = 0;
    int n_fail  = 0;
    int rst_cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    wdg_top #(.PULSE_LEN(PL)) i_wdg_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .tick(tick), .wdg_rst(wdg_rst)
    );

    always @(negedge clk) if (wdg_rst) rst_cycles++;

    function automatic int exp_delay(input int c);
        case (c) 1: return 3; 2: return 60; 7: return 60; default: return 0; endcase
    endfunction
    function automatic int exp_to(input int c);
        case (c) 1: return 3; 2: return 1; 5: return 1; 6: return 10; 7: return 10; default: return 0; endcase
    endfunction
    function automatic bit exp_en(input int c);
        return exp_to(c) != 0;
    endfunction

    task automatic chk(input int act, input int exp, input string req);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk); wr_en = 1'b1; wr_data = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic kick(input logic [7:0] v);
        wr(v | 8'h08);
        wr(v & 8'hF7);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic pulse_out(input string req);
        int len = 0;
        while (wdg_rst) begin len++; @(negedge clk); end
        chk(len, PL, req);
    endtask

    task automatic fire_after(input int n, input string req);
        if (n > 1) ticks(n - 1);
        chk(wdg_rst, 0, req);
        ticks(1);
        chk(wdg_rst, 1, req);
        pulse_out({req, " pulse length"});
    endtask

    initial begin
        int snap;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(rd_data, 8'h03, "R1 reset value");
        chk(wdg_rst, 0, "R1 reset output");
        wr(8'h5B);
        chk(rd_data, 8'h5B, "R1 readback");

        // sweep every code
        for (int c = 0; c < 8; c++) begin
            wr(8'(c));
            if (!exp_en(c)) begin
                snap = rst_cycles;
                ticks(150); kick(8'(c)); ticks(20);
                chk(rst_cycles - snap, 0, "R2 disabled code");
            end else if (exp_delay(c) > 0) begin
                fire_after(exp_delay(c) + exp_to(c), (c == 1) ? "R4 code 1" : "R5 delayed code");
                fire_after(exp_delay(c) + exp_to(c), "R10 repeat after pulse");
            end else begin
                snap = rst_cycles;
                ticks(100);
                chk(rst_cycles - snap, 0, "R7 idle before kick");
                kick(8'(c));
                fire_after(exp_to(c), "R6 zero-delay code");
                snap = rst_cycles;
                ticks(50);
                chk(rst_cycles - snap, 0, "R10 back to waiting");
            end
        end

        // R9: no tick, no progress
        wr(8'h06);
        kick(8'h06);
        snap = rst_cycles;
        repeat (500) @(negedge clk);
        chk(rst_cycles - snap, 0, "R9 clocks without tick");
        fire_after(10, "R9 ticks resume");

        // R12: kick while running
        wr(8'h07);
        ticks(60 + 9);
        kick(8'h07);
        fire_after(10, "R12 kick restarts count");

        // R8: kick during delay ignored
        wr(8'h01);
        ticks(2);
        kick(8'h01);
        fire_after(1 + 3, "R8 kick in delay");

        // R3: level is not an edge
        wr(8'h0E);            // code change to 6 with bit 3 set
        wr(8'h0E);            // bit 3 still 1: no kick
        snap = rst_cycles;
        ticks(20);
        wr(8'h06);            // falling: no kick
        ticks(20);
        chk(rst_cycles - snap, 0, "R3 no edge no kick");
        wr(8'h0E);            // rising: kick
        fire_after(10, "R3 rising edge kick");

        // R11: upper-bit write keeps count, code change restarts
        wr(8'h07);
        ticks(40);
        wr(8'hA7);
        chk(rd_data, 8'hA7, "R11 upper bits stored");
        fire_after(70 - 40, "R11 no restart on upper bits");
        ticks(50);
        wr(8'hA2);
        fire_after(60 + 1, "R11 restart on code change");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule